// File: doc/BRIEF.md
# Maintenance range chunking sequencer

This block sits in front of a cache maintenance executor. Software-side logic hands it one byte range, given as a start address and an exclusive end address, together with an operation: invalidate, clean, or flush. The executor accepts only bounded range commands. Each of these commands names an inclusive first line and an inclusive last line. The executor also accepts single-line clean-and-invalidate commands. The sequencer aligns the range to 32-byte lines and handles the partial lines at its edges. It cuts the range into chunks that are never longer than 1024 bytes and never cross a page. It passes each command out over a valid/ready handshake.

A write-through mode can be set with each request. In that mode the cache never holds dirty lines, so clean commands are dropped. When every command of a request has been accepted, the sequencer raises a barrier request. Once the barrier is taken, it pulses a completion flag and returns to idle. Only one request is in flight at any time.

Top module: `maint_range_seq`

## Requirements
- R1: `req_ready` is 1 only while idle with no command or barrier pending; a request is taken on `req_valid && req_ready`, and `req_valid` while busy has no effect on the command stream.
- R2: Every command carries 32-byte-aligned `cmd_first` and `cmd_last`; for a range command `cmd_last` is the chunk's exclusive end minus 32.
- R3: A chunk starting at running address S ends at the smallest of the aligned end, S+1024, and the next page boundary above S (page 4096 bytes), so no range command spans more than 1024 bytes or two pages.
- R4: For invalidate (`req_op`=0) with an unaligned start, the first command is kind 0 (single-line clean-and-invalidate) on the start's line base, and range work begins at the next line boundary.
- R5: For invalidate with an unaligned end, a kind 0 command on the end's line base follows any head command and precedes all range commands, and range work stops at that base.
- R6: For clean (`req_op`=1) and flush (`req_op`=2; code 3 acts as flush), start is rounded down and end rounded up to 32 bytes before chunking.
- R7: Each flush chunk is a kind 1 (range clean) command followed by a kind 2 (range invalidate) command with identical first and last addresses.
- R8: With `wt_mode`=1 at acceptance, clean issues no command, and flush issues only kind 2 commands.
- R9: A request with `req_end` <= `req_start`, or one whose aligned range is empty, issues no range command but still raises the barrier and completes.
- R10: `bar_valid` rises only after the last command has been accepted; `done` pulses for one cycle in the cycle after the barrier handshake.
- R11: While `cmd_valid` is high and `cmd_ready` low, `cmd_kind`, `cmd_first` and `cmd_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wt_mode | input | 1 | Write-through mode, sampled with the request |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 flush |
| req_start | input | ADDR_W | First byte of the range |
| req_end | input | ADDR_W | Byte after the last one in the range |
| cmd_valid | output | 1 | Command offered to the executor |
| cmd_ready | input | 1 | Executor accepts the command |
| cmd_kind | output | 2 | 0 line clean-and-invalidate, 1 range clean, 2 range invalidate |
| cmd_first | output | ADDR_W | Inclusive first line address |
| cmd_last | output | ADDR_W | Inclusive last line address |
| bar_valid | output | 1 | Barrier request |
| bar_ready | input | 1 | Barrier accepted |
| done | output | 1 | One-cycle completion pulse |

## Verification
A corrupt running address or aligned end appears at the ports at the very next command handshake. It shows up as a wrong `cmd_first` or `cmd_last`, as a missing or surplus chunk, or as a barrier raised with commands still owed. A lost edge flag or a wrong flush sub-step changes the kind sequence within one command. A stuck sequencing state shows as `req_ready` staying low, or as `done` never arriving. The reference model predicts the full ordered command list for each request and compares every accepted command against it at the cycle of its handshake, under both continuous and throttled readiness.

// File: rtl/rcs_pkg.sv
// Shared codes for the maintenance range chunking sequencer.
// Assumes two-bit operation and command kind fields at the ports.
package rcs_pkg;

    localparam logic [1:0] OP_INV   = 2'd0;
    localparam logic [1:0] OP_CLEAN = 2'd1;
    localparam logic [1:0] OP_FLUSH = 2'd2;

    localparam logic [1:0] KIND_LINE_CI = 2'd0;
    localparam logic [1:0] KIND_RCLEAN  = 2'd1;
    localparam logic [1:0] KIND_RINV    = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAN,
        ST_HEAD,
        ST_TAIL,
        ST_RCLN,
        ST_RINV,
        ST_BAR
    } seq_state_e;

endpackage

// File: rtl/rcs_align.sv
// Edge alignment for one request.
// It turns a byte range with an exclusive end into a line-aligned running start
// and stop (one extra bit so that the top of the address space can be
// represented), plus the single-line edge work an invalidate needs.
// Assumes LINE_BYTES is a power of two.
module rcs_align
    import rcs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] start_a,
    input  logic [ADDR_W-1:0] end_a,
    output logic [ADDR_W:0]   run_start,
    output logic [ADDR_W:0]   run_stop,
    output logic              head_pend,
    output logic              tail_pend,
    output logic [ADDR_W-1:0] head_base,
    output logic [ADDR_W-1:0] tail_base
);

    localparam int             LSB    = $clog2(LINE_BYTES);
    localparam logic [ADDR_W:0] LINE_W = (ADDR_W+1)'(LINE_BYTES);

    logic             empty;
    logic             start_off;
    logic             end_off;
    logic [ADDR_W:0]  s_base;
    logic [ADDR_W:0]  e_base;

    // Derive line bases, edge flags and the aligned running window.
    always_comb begin
        empty     = (end_a <= start_a);
        start_off = |start_a[LSB-1:0];
        end_off   = |end_a[LSB-1:0];
        head_base = {start_a[ADDR_W-1:LSB], {LSB{1'b0}}};
        tail_base = {end_a[ADDR_W-1:LSB], {LSB{1'b0}}};
        s_base    = {1'b0, head_base};
        e_base    = {1'b0, tail_base};
        head_pend = 1'b0;
        tail_pend = 1'b0;
        run_start = '0;
        run_stop  = '0;
        if (!empty) begin
            if (op == OP_INV) begin
                head_pend = start_off;
                tail_pend = end_off;
                run_start = start_off ? (s_base + LINE_W) : s_base;
                run_stop  = e_base;
            end else begin
                run_start = s_base;
                run_stop  = end_off ? (e_base + LINE_W) : e_base;
            end
        end
    end

endmodule

// File: rtl/rcs_chunk.sv
// Chunk boundary selection.
// Given an aligned running address and stop, it returns the exclusive end of
// the next chunk: the nearest of the stop, the size cap and the page boundary.
// Assumes PAGE_BYTES is a power of two and cur is below stop when used.
module rcs_chunk #(
    parameter int ADDR_W      = 32,
    parameter int CHUNK_BYTES = 1024,
    parameter int PAGE_BYTES  = 4096
) (
    input  logic [ADDR_W:0] cur,
    input  logic [ADDR_W:0] stop,
    output logic [ADDR_W:0] chunk_end
);

    localparam logic [ADDR_W:0] CAP   = (ADDR_W+1)'(CHUNK_BYTES);
    localparam logic [ADDR_W:0] PMASK = (ADDR_W+1)'(PAGE_BYTES - 1);
    localparam logic [ADDR_W:0] ONE   = (ADDR_W+1)'(1);

    logic [ADDR_W:0] by_cap;
    logic [ADDR_W:0] by_page;

    // Pick the minimum of the three candidate ends.
    always_comb begin
        by_cap    = cur + CAP;
        by_page   = (cur | PMASK) + ONE;
        chunk_end = stop;
        if (by_cap < chunk_end) begin
            chunk_end = by_cap;
        end
        if (by_page < chunk_end) begin
            chunk_end = by_page;
        end
    end

endmodule

// File: rtl/maint_range_seq.sv
// Maintenance range chunking sequencer (top).
// It takes one range request at a time, issues the edge and range commands
// to the executor over a valid/ready handshake, then requests a barrier and
// pulses done. Between steps it passes through a planning cycle, which
// picks the next step from registered state.
// Assumes the executor holds no ordering constraint beyond in-order acceptance.
module maint_range_seq
    import rcs_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LINE_BYTES  = 32,
    parameter int CHUNK_BYTES = 1024,
    parameter int PAGE_BYTES  = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wt_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_kind,
    output logic [ADDR_W-1:0] cmd_first,
    output logic [ADDR_W-1:0] cmd_last,
    output logic              bar_valid,
    input  logic              bar_ready,
    output logic              done
);

    localparam int                LSB      = $clog2(LINE_BYTES);
    localparam int                PAGE_LSB = $clog2(PAGE_BYTES);
    localparam logic [ADDR_W-1:0] LINE_A   = ADDR_W'(LINE_BYTES);
    localparam logic [ADDR_W-1:0] CAP_A    = ADDR_W'(CHUNK_BYTES);

    seq_state_e        state;
    seq_state_e        plan_next;
    logic [1:0]        op_q;
    logic              wt_q;
    logic [ADDR_W:0]   cur_q;
    logic [ADDR_W:0]   stop_q;
    logic              head_q;
    logic              tail_q;
    logic [ADDR_W-1:0] head_base_q;
    logic [ADDR_W-1:0] tail_base_q;
    logic              done_q;

    logic [ADDR_W:0]   al_start;
    logic [ADDR_W:0]   al_stop;
    logic              al_head;
    logic              al_tail;
    logic [ADDR_W-1:0] al_head_base;
    logic [ADDR_W-1:0] al_tail_base;
    logic [ADDR_W:0]   chunk_end;

    logic              has_range;
    logic              want_clean;
    logic              want_inv;
    logic              cmd_fire;

    rcs_align #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES)
    ) u_align (
        .op        (req_op),
        .start_a   (req_start),
        .end_a     (req_end),
        .run_start (al_start),
        .run_stop  (al_stop),
        .head_pend (al_head),
        .tail_pend (al_tail),
        .head_base (al_head_base),
        .tail_base (al_tail_base)
    );

    rcs_chunk #(
        .ADDR_W      (ADDR_W),
        .CHUNK_BYTES (CHUNK_BYTES),
        .PAGE_BYTES  (PAGE_BYTES)
    ) u_chunk (
        .cur       (cur_q),
        .stop      (stop_q),
        .chunk_end (chunk_end)
    );

    // Decode which range sub-commands the held request needs.
    always_comb begin
        has_range  = (cur_q < stop_q);
        want_clean = !wt_q && (op_q != OP_INV);
        want_inv   = (op_q != OP_CLEAN);
    end

    // Choose the next step: edges first, then chunks, then the barrier.
    always_comb begin
        if (head_q) begin
            plan_next = ST_HEAD;
        end else if (tail_q) begin
            plan_next = ST_TAIL;
        end else if (has_range && want_clean) begin
            plan_next = ST_RCLN;
        end else if (has_range && want_inv) begin
            plan_next = ST_RINV;
        end else begin
            plan_next = ST_BAR;
        end
    end

    // Drive the command port from the current step.
    always_comb begin
        cmd_valid = 1'b0;
        cmd_kind  = KIND_RINV;
        cmd_first = cur_q[ADDR_W-1:0];
        cmd_last  = chunk_end[ADDR_W-1:0] - LINE_A;
        unique case (state)
            ST_HEAD: begin
                cmd_valid = 1'b1;
                cmd_kind  = KIND_LINE_CI;
                cmd_first = head_base_q;
                cmd_last  = head_base_q;
            end
            ST_TAIL: begin
                cmd_valid = 1'b1;
                cmd_kind  = KIND_LINE_CI;
                cmd_first = tail_base_q;
                cmd_last  = tail_base_q;
            end
            ST_RCLN: begin
                cmd_valid = 1'b1;
                cmd_kind  = KIND_RCLEAN;
            end
            ST_RINV: begin
                cmd_valid = 1'b1;
                cmd_kind  = KIND_RINV;
            end
            default: begin
                cmd_valid = 1'b0;
            end
        endcase
    end

    assign req_ready = (state == ST_IDLE);
    assign bar_valid = (state == ST_BAR);
    assign done      = done_q;
    assign cmd_fire  = cmd_valid && cmd_ready;

    // Sequence state, request capture and running address advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            op_q        <= OP_INV;
            wt_q        <= 1'b0;
            cur_q       <= '0;
            stop_q      <= '0;
            head_q      <= 1'b0;
            tail_q      <= 1'b0;
            head_base_q <= '0;
            tail_base_q <= '0;
            done_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q        <= req_op;
                        wt_q        <= wt_mode;
                        cur_q       <= al_start;
                        stop_q      <= al_stop;
                        head_q      <= al_head;
                        tail_q      <= al_tail;
                        head_base_q <= al_head_base;
                        tail_base_q <= al_tail_base;
                        state       <= ST_PLAN;
                    end
                end
                ST_PLAN: begin
                    state <= plan_next;
                end
                ST_HEAD: begin
                    if (cmd_ready) begin
                        head_q <= 1'b0;
                        state  <= ST_PLAN;
                    end
                end
                ST_TAIL: begin
                    if (cmd_ready) begin
                        tail_q <= 1'b0;
                        state  <= ST_PLAN;
                    end
                end
                ST_RCLN: begin
                    if (cmd_ready) begin
                        if (want_inv) begin
                            state <= ST_RINV;
                        end else begin
                            cur_q <= chunk_end;
                            state <= ST_PLAN;
                        end
                    end
                end
                ST_RINV: begin
                    if (cmd_ready) begin
                        cur_q <= chunk_end;
                        state <= ST_PLAN;
                    end
                end
                ST_BAR: begin
                    if (bar_ready) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Idle means nothing is owed to the executor.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!cmd_valid && !bar_valid));

    // Every command names whole lines.
    p_line_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_first[LSB-1:0] == '0 && cmd_last[LSB-1:0] == '0));

    // Range commands respect the size cap.
    p_chunk_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind != KIND_LINE_CI) |-> ((cmd_last - cmd_first) < CAP_A));

    // Range commands stay inside one page.
    p_one_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind != KIND_LINE_CI) |->
            (cmd_first[ADDR_W-1:PAGE_LSB] == cmd_last[ADDR_W-1:PAGE_LSB]));

    // A flush clean is followed at once by an invalidate of the same span.
    p_flush_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && cmd_kind == KIND_RCLEAN && op_q != OP_CLEAN) |=>
            (cmd_valid && cmd_kind == KIND_RINV && $stable(cmd_first) && $stable(cmd_last)));

    // Write-through mode never emits a range clean.
    p_wt_no_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && wt_q) |-> (cmd_kind != KIND_RCLEAN));

    // Done follows an accepted barrier.
    p_done_after_bar_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bar_valid && bar_ready));

    // A stalled command keeps its fields.
    p_hold_stalled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=>
            (cmd_valid && $stable(cmd_kind) && $stable(cmd_first) && $stable(cmd_last)));

endmodule

// File: tb/maint_range_seq_bench.sv
// Bench: a behavioural model builds the ordered command list of each
// request; a negedge monitor compares every handshake as it occurs.
module maint_range_seq_bench;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wt_mode = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_start = '0;
    logic [AW-1:0] req_end = '0;
    logic          cmd_valid;
    logic          cmd_ready = 1'b0;
    logic [1:0]    cmd_kind;
    logic [AW-1:0] cmd_first;
    logic [AW-1:0] cmd_last;
    logic          bar_valid;
    logic          bar_ready = 1'b0;
    logic          done;

    int     checks = 0;
    int     fails = 0;
    int     cyc = 0;
    int     stall = 0;
    int     bar_seen = 0;
    int     done_seen = 0;
    string  cur_tag = "";
    int     q_kind[$];
    longint q_first[$];
    longint q_last[$];

    maint_range_seq u_maint_range_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wt_mode   (wt_mode),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_start (req_start),
        .req_end   (req_end),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_kind  (cmd_kind),
        .cmd_first (cmd_first),
        .cmd_last  (cmd_last),
        .bar_valid (bar_valid),
        .bar_ready (bar_ready),
        .done      (done)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input int k, input longint f, input longint l);
        q_kind.push_back(k);
        q_first.push_back(f);
        q_last.push_back(l);
    endtask

    // Reference model: ordered commands for one request.
    task automatic build(input int op, input bit wt, input longint s_in, input longint e_in);
        longint m;
        longint s;
        longint e;
        longint re;
        m = 31;
        s = s_in;
        e = e_in;
        if (e <= s) return;
        if (op == 0) begin
            if ((s & m) != 0) begin
                push(0, s & ~m, s & ~m);
                s = (s | m) + 1;
            end
            if ((e & m) != 0) begin
                push(0, e & ~m, e & ~m);
                e = e & ~m;
            end
        end else begin
            s = s & ~m;
            e = (e + m) & ~m;
        end
        while (s < e) begin
            re = e;
            if (re > s + 1024) re = s + 1024;
            if (re > ((s | 4095) + 1)) re = (s | 4095) + 1;
            if (op != 0 && !wt) push(1, s, re - 32);
            if (op != 1) push(2, s, re - 32);
            s = re;
        end
    endtask

    // Monitor: drive readiness and compare each handshake at the negedge.
    always @(negedge clk) begin : mon
        bit cr;
        bit br;
        cyc++;
        if (rst_n) begin
            cr = (stall == 0) || ((cyc % stall) != 0);
            br = (stall == 0) || ((cyc % 2) == 0);
            cmd_ready = cr;
            bar_ready = br;
            if (cmd_valid && cr) begin
                if (q_kind.size() == 0) begin
                    check(1'b0, cur_tag, "unexpected command first", longint'(cmd_first), 0);
                end else begin
                    check(int'(cmd_kind) == q_kind[0], cur_tag, "kind",
                          longint'(cmd_kind), longint'(q_kind[0]));
                    check(longint'(cmd_first) == q_first[0], cur_tag, "first",
                          longint'(cmd_first), q_first[0]);
                    check(longint'(cmd_last) == q_last[0], cur_tag, "last",
                          longint'(cmd_last), q_last[0]);
                    void'(q_kind.pop_front());
                    void'(q_first.pop_front());
                    void'(q_last.pop_front());
                end
            end
            if (bar_valid && br) begin
                check(q_kind.size() == 0, "R10", "commands owed at barrier",
                      longint'(q_kind.size()), 0);
                bar_seen++;
            end
            if (done) done_seen++;
        end
    end

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R10 watchdog: actual %0d expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic run(input int op, input bit wt, input longint s, input longint e,
                       input string tag, input bit noise);
        int b0;
        int d0;
        int guard;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready before request", longint'(req_ready), 1);
        build(op, wt, s, e);
        cur_tag = tag;
        b0 = bar_seen;
        d0 = done_seen;
        req_op = 2'(op);
        wt_mode = wt;
        req_start = s[31:0];
        req_end = e[31:0];
        req_valid = 1'b1;
        @(negedge clk);
        if (noise) begin
            req_op = 2'd0;
            req_start = 32'h8000_0044;
            req_end = 32'h8000_0107;
            repeat (3) @(negedge clk);
        end
        req_valid = 1'b0;
        guard = 0;
        while (done_seen == d0 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check(guard < 5000, "R10", "done timeout", guard, 0);
        check(q_kind.size() == 0, tag, "commands never issued", longint'(q_kind.size()), 0);
        check(bar_seen == b0 + 1, "R10", "barrier count", bar_seen - b0, 1);
        repeat (3) @(negedge clk);
        check(done_seen == d0 + 1, "R10", "done pulse count", done_seen - d0, 1);
        check(!cmd_valid && !bar_valid, "R1", "quiet after completion",
              longint'({cmd_valid, bar_valid}), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "reset ready", longint'(req_ready), 1);
        check(cmd_valid == 1'b0, "R1", "reset cmd_valid", longint'(cmd_valid), 0);
        check(bar_valid == 1'b0, "R10", "reset bar_valid", longint'(bar_valid), 0);
        check(done == 1'b0, "R10", "reset done", longint'(done), 0);

        run(0, 0, 64'h1005, 64'h1F3B, "R4 R5 R2 R3", 0);
        run(1, 0, 64'h0F90, 64'h1430, "R6 R3", 0);
        stall = 3;
        run(2, 0, 64'h3000, 64'h3800, "R7 R11", 0);
        run(0, 0, 64'h2FF0, 64'h3411, "R4 R5 R11", 0);
        stall = 0;
        run(2, 1, 64'h5010, 64'h5C20, "R8 flush", 0);
        run(1, 1, 64'h6000, 64'h6400, "R8 clean", 0);
        run(0, 1, 64'h6003, 64'h6047, "R8 inv edges", 0);
        run(1, 0, 64'h7000, 64'h7000, "R9 equal", 0);
        run(2, 0, 64'h7100, 64'h7000, "R9 reversed", 0);
        run(0, 0, 64'h0105, 64'h010A, "R9 R4 R5 one line", 0);
        run(0, 0, 64'h4000, 64'h4400, "R3 R2 exact cap", 0);
        run(2, 0, 64'hFFFF_FF10, 64'hFFFF_FFF1, "R6 R2 top", 0);
        run(3, 0, 64'h8010, 64'h8050, "R6 R7 code3", 0);
        run(2, 0, 64'h5000, 64'h5800, "R1 busy ignored", 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule